// File: doc/BRIEF.md
# Maskable Interrupt Priority Resolver with Acknowledge Capture

The resolver looks at every maskable interrupt group, finds the group that is pending with the most urgent priority, and drives that group's 3-bit priority level to the processor from a register. A group is pending when some bit of its request vector is also set in its enable vector. A smaller level number is more urgent. The all-ones level (7) means that no maskable interrupt is requested.

When the processor accepts an interrupt, it strobes an acknowledge together with the level it believes it is taking. The resolver stores the number of the group it is currently presenting into a capture register that software can read. The first read byte holds the group number times four, or zero if that group has stopped pending since the capture. A separate one-cycle pulse tells the processor about a non-maskable request. That pulse fires when one of the low, non-maskable groups sees an input event while it is pending.

Request, enable and level storage, and the detection of input edges and levels, are done outside this block.

Top module: `irq_level_resolver`

## Requirements
- R1: A group counts as pending only when the bitwise AND of its 4-bit request and 4-bit enable vectors is nonzero; a request bit whose enable bit is clear has no effect on `level_out`.
- R2: Only groups NMI_GROUPS (2) to LAST_GROUP (30) take part in level selection; requests on groups 0 and 1 never change `level_out`.
- R3: Among pending groups, the one with the numerically smallest 3-bit level is selected and its level is driven on `level_out`.
- R4: When several pending groups share the smallest level, the lowest-numbered group is selected.
- R5: When no competing group is pending, or the pending ones all have level 7, `level_out` is 7 and the selected group number is 0.
- R6: `level_out` is registered: it changes on the first rising clock edge after a change to request, enable or level inputs, and not before.
- R7: A cycle with `ack_valid` high stores the group number selected by the current `level_out` into the capture register; a read with `rd_byte` = 0 then returns that number shifted left by two bits.
- R8: A read with `rd_byte` = 0 returns zero if the captured group is no longer pending.
- R9: A read with `rd_byte` = 1 always returns zero.
- R10: A write strobe `wr_en` leaves the capture register unchanged, as seen on the read data.
- R11: `nmi_pulse` is high for exactly one cycle after a cycle in which `nmi_event[g]` is high while group g (g < NMI_GROUPS) is pending, and low otherwise.
- R12: `ack_mismatch` is high in any cycle in which `ack_valid` is high and `ack_level` differs from `level_out`, and low otherwise.
- R13: After reset, `level_out` is 7, `nmi_pulse` is 0 and the read data for byte 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_req | input | 124 | Request bits, 4 per group, group g at [4g+3:4g] |
| grp_en | input | 124 | Enable bits, same layout as grp_req |
| grp_lvl | input | 87 | Levels of groups 2..30, group g at [3(g-2)+2:3(g-2)] |
| nmi_event | input | 2 | Input-event strobe for non-maskable groups 0 and 1 |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_level | input | 3 | Level the processor is acknowledging |
| rd_byte | input | 1 | Byte select of the capture register read |
| wr_en | input | 1 | Write strobe to the capture register (discarded) |
| level_out | output | 3 | Registered level of the selected group, 7 when idle |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request |
| ack_mismatch | output | 1 | Acknowledged level differs from level_out |
| rd_data | output | 8 | Capture register read data |

## Verification
A fault in the priority scan shows up on `level_out` one clock after the inputs settle. It shows either as a wrong level or as a stale level. A wrong choice between groups of equal level is not visible on the level. It only appears at the next acknowledge, when the read data shows the wrong group number. A corrupted capture register stays hidden until the next read of byte 0. Random request patterns with frequent acknowledges and reads keep that delay to a few cycles.

// File: rtl/irq_res_pkg.sv
// Shared constants and types for the interrupt priority resolver.
package irq_res_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t IDLE_LVL = '1;
endpackage

// File: rtl/irq_pend_detect.sv
// Pending detector: one flag per group, set when request AND enable is
// nonzero. Assumes request and enable are packed SRC_W bits per group.
module irq_pend_detect #(
    parameter int NUM_GROUPS = 31,
    parameter int SRC_W      = 4
) (
    input  logic [NUM_GROUPS*SRC_W-1:0] req,
    input  logic [NUM_GROUPS*SRC_W-1:0] en,
    output logic [NUM_GROUPS-1:0]       pend
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_pend
        // reduce the masked request of one group to a single flag
        assign pend[g] = |(req[g*SRC_W +: SRC_W] & en[g*SRC_W +: SRC_W]);
    end
endmodule

// File: rtl/irq_prio_scan.sv
// Priority scan: walks the competing groups in ascending order and keeps
// a group only when its level is strictly smaller, so ties go to the
// lowest number. The result is registered. Assumes pend/lvl are indexed
// from the first competing group.
module irq_prio_scan
    import irq_res_pkg::*;
#(
    parameter int NUM_LVL = 29,
    parameter int FIRST   = 2,
    parameter int GID_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_LVL-1:0]       pend,
    input  logic [NUM_LVL*LVL_W-1:0] lvl,
    output lvl_t                     level_q,
    output logic [GID_W-1:0]         sel_q
);
    lvl_t             best_lvl;
    logic [GID_W-1:0] best_gid;

    // linear search for the most urgent pending group
    always_comb begin
        best_lvl = IDLE_LVL;
        best_gid = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (pend[i] && (lvl[i*LVL_W +: LVL_W] < best_lvl)) begin
                best_lvl = lvl[i*LVL_W +: LVL_W];
                best_gid = GID_W'(i + FIRST);
            end
        end
    end

    // register the chosen level and group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= IDLE_LVL;
            sel_q   <= '0;
        end else begin
            level_q <= best_lvl;
            sel_q   <= best_gid;
        end
    end

    // R5
    idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == '0) |-> (level_q == IDLE_LVL));
    // R2
    sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != '0) |-> (int'(sel_q) >= FIRST && int'(sel_q) < FIRST + NUM_LVL));
endmodule

// File: rtl/irq_ack_capture.sv
// Acknowledge capture: stores the presented group on ack and serves the
// read port. Byte 0 is group*4 while that group still pends, byte 1 is 0.
// The write strobe is accepted and discarded.
module irq_ack_capture #(
    parameter int NUM_GROUPS = 31,
    parameter int GID_W      = 5,
    parameter int DATA_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ack_valid,
    input  logic [GID_W-1:0]      sel_in,
    input  logic [NUM_GROUPS-1:0] pend,
    input  logic                  rd_byte,
    input  logic                  wr_en,
    output logic [DATA_W-1:0]     rd_data
);
    logic [GID_W-1:0] acc_q;
    logic             acc_live;

    // capture the presented group on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)         acc_q <= '0;
        else if (ack_valid) acc_q <= sel_in;
    end

    // look up whether the captured group still pends
    always_comb begin
        acc_live = 1'b0;
        for (int g = 0; g < NUM_GROUPS; g++)
            if (int'(acc_q) == g) acc_live = pend[g];
    end

    // read data mux
    always_comb begin
        rd_data = '0;
        if (!rd_byte && acc_live) rd_data = DATA_W'({acc_q, 2'b00});
    end

    // R7
    ack_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> (acc_q == $past(sel_in)));
    // R10
    write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ack_valid) |=> $stable(acc_q));
    // R7
    rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[1:0] == 2'b00);
endmodule

// File: rtl/irq_level_resolver.sv
// Top: pending detection, registered priority scan, acknowledge capture,
// NMI pulse and acknowledge-level check. Groups below NMI_GROUPS are
// non-maskable; groups NMI_GROUPS..LAST_GROUP compete by level.
module irq_level_resolver
    import irq_res_pkg::*;
#(
    parameter int NMI_GROUPS = 2,
    parameter int LAST_GROUP = 30,
    parameter int SRC_W      = 4,
    parameter int DATA_W     = 8,
    localparam int NUM_GROUPS = LAST_GROUP + 1,
    localparam int NUM_LVL    = NUM_GROUPS - NMI_GROUPS,
    localparam int GID_W      = $clog2(NUM_GROUPS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*SRC_W-1:0] grp_req,
    input  logic [NUM_GROUPS*SRC_W-1:0] grp_en,
    input  logic [NUM_LVL*LVL_W-1:0]    grp_lvl,
    input  logic [NMI_GROUPS-1:0]       nmi_event,
    input  logic                        ack_valid,
    input  logic [LVL_W-1:0]            ack_level,
    input  logic                        rd_byte,
    input  logic                        wr_en,
    output logic [LVL_W-1:0]            level_out,
    output logic                        nmi_pulse,
    output logic                        ack_mismatch,
    output logic [DATA_W-1:0]           rd_data
);
    logic [NUM_GROUPS-1:0] pend;
    logic [GID_W-1:0]      sel_q;
    logic                  nmi_q;

    irq_pend_detect #(.NUM_GROUPS(NUM_GROUPS), .SRC_W(SRC_W)) u_pend (
        .req (grp_req),
        .en  (grp_en),
        .pend(pend)
    );

    irq_prio_scan #(.NUM_LVL(NUM_LVL), .FIRST(NMI_GROUPS), .GID_W(GID_W)) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend[NUM_GROUPS-1:NMI_GROUPS]),
        .lvl    (grp_lvl),
        .level_q(level_out),
        .sel_q  (sel_q)
    );

    irq_ack_capture #(.NUM_GROUPS(NUM_GROUPS), .GID_W(GID_W), .DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_valid(ack_valid),
        .sel_in   (sel_q),
        .pend     (pend),
        .rd_byte  (rd_byte),
        .wr_en    (wr_en),
        .rd_data  (rd_data)
    );

    // one-cycle NMI pulse on an event to a pending non-maskable group
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_q <= 1'b0;
        else        nmi_q <= |(nmi_event & pend[NMI_GROUPS-1:0]);
    end
    assign nmi_pulse = nmi_q;

    // compare the acknowledged level with the one being presented
    assign ack_mismatch = ack_valid && (ack_level != level_out);

    // R5
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pend[NUM_GROUPS-1:NMI_GROUPS]) |=> (level_out == IDLE_LVL));
    // R11
    nmi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |-> $past(|nmi_event));
    // R12
    mismatch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_mismatch |-> ack_valid);
endmodule

// File: tb/irq_level_resolver_tb.sv
`timescale 1ns/1ps
module irq_level_resolver_tb_top;
    localparam int NG = 31, NL = 29, FIRST = 2, SW = 4, LW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NG*SW-1:0]  grp_req = '0, grp_en = '0;
    logic [NL*LW-1:0]  grp_lvl = '0;
    logic [1:0]        nmi_event = '0;
    logic              ack_valid = 1'b0;
    logic [2:0]        ack_level = '0;
    logic              rd_byte = 1'b0, wr_en = 1'b0;
    logic [2:0]        level_out;
    logic              nmi_pulse, ack_mismatch;
    logic [7:0]        rd_data;

    int tests = 0, fails = 0;
    bit done = 0;
    int exp_acc = 0;

    always #2 clk = ~clk;

    irq_level_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .grp_req(grp_req), .grp_en(grp_en),
        .grp_lvl(grp_lvl), .nmi_event(nmi_event), .ack_valid(ack_valid),
        .ack_level(ack_level), .rd_byte(rd_byte), .wr_en(wr_en),
        .level_out(level_out), .nmi_pulse(nmi_pulse),
        .ack_mismatch(ack_mismatch), .rd_data(rd_data)
    );

    function automatic bit pend_of(int g);
        return |(grp_req[g*SW +: SW] & grp_en[g*SW +: SW]);
    endfunction

    function automatic void model(output int sel, output int lv);
        sel = 0; lv = 7;
        for (int g = FIRST; g < NG; g++)
            if (pend_of(g) && int'(grp_lvl[(g-FIRST)*LW +: LW]) < lv) begin
                sel = g; lv = int'(grp_lvl[(g-FIRST)*LW +: LW]);
            end
    endfunction

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic set_grp(int g, logic [3:0] r, logic [3:0] e, logic [2:0] l);
        grp_req[g*SW +: SW] = r;
        grp_en[g*SW +: SW]  = e;
        if (g >= FIRST) grp_lvl[(g-FIRST)*LW +: LW] = l;
    endtask

    task automatic do_ack(logic [2:0] l, int exp_mis);
        ack_valid = 1'b1; ack_level = l; #1;
        chk("R12 mismatch", int'(ack_mismatch), exp_mis);
        step();
        ack_valid = 1'b0; #1;
        chk("R12 idle", int'(ack_mismatch), 0);
    endtask

    task automatic check_read(string tag);
        int e;
        rd_byte = 1'b0; #1;
        e = pend_of(exp_acc) ? exp_acc * 4 : 0;
        chk(tag, int'(rd_data), e);
    endtask

    task automatic check_level(string tag);
        int s, l;
        model(s, l);
        chk(tag, int'(level_out), l);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int s, l;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1; #1;
        // R13 reset state
        chk("R13 level", int'(level_out), 7);
        chk("R13 nmi", int'(nmi_pulse), 0);
        chk("R13 read", int'(rd_data), 0);

        // R1 request without enable has no effect
        set_grp(5, 4'b0010, 4'b0001, 3'd3); step();
        chk("R1 masked", int'(level_out), 7);
        // R6 not visible before the edge
        set_grp(5, 4'b0010, 4'b0010, 3'd3); #1;
        chk("R6 before edge", int'(level_out), 7);
        step();
        chk("R6 after edge / R1", int'(level_out), 3);

        // R2 non-maskable groups do not compete
        set_grp(0, 4'hf, 4'hf, 3'd0); set_grp(1, 4'hf, 4'hf, 3'd0); step();
        chk("R2 nmi groups", int'(level_out), 3);
        set_grp(0, 4'h0, 4'h0, 3'd0); set_grp(1, 4'h0, 4'h0, 3'd0);

        // R3 smaller level wins
        set_grp(10, 4'b1000, 4'b1000, 3'd1); step();
        chk("R3 smaller wins", int'(level_out), 1);

        // R4 tie goes to lower number, seen via ack read
        set_grp(12, 4'b0001, 4'b0001, 3'd1); step();
        chk("R4 tie level", int'(level_out), 1);
        do_ack(3'd1, 0); exp_acc = 10;
        check_read("R4 R7 tie group");
        do_ack(3'd4, 1);
        check_read("R12 R7 after mismatch ack");

        // R9 upper byte
        rd_byte = 1'b1; #1;
        chk("R9 byte1", int'(rd_data), 0);
        rd_byte = 1'b0;

        // R10 write is discarded
        wr_en = 1'b1; step(); wr_en = 1'b0;
        check_read("R10 after write");

        // R8 captured group no longer pending
        set_grp(10, 4'b1000, 4'b0000, 3'd1); #1;
        check_read("R8 gone");
        chk("R8 gone value", int'(rd_data), 0);
        step();
        check_level("R3 after drop");

        // R11 NMI
        set_grp(0, 4'b0001, 4'b0001, 3'd0);
        nmi_event = 2'b01; step(); nmi_event = 2'b00; #1;
        chk("R11 pulse", int'(nmi_pulse), 1);
        step();
        chk("R11 one cycle", int'(nmi_pulse), 0);
        nmi_event = 2'b10; step(); nmi_event = 2'b00; #1;
        chk("R11 not pending", int'(nmi_pulse), 0);
        set_grp(0, 4'h0, 4'h0, 3'd0);

        // R5 level 7 pending and empty
        grp_req = '0; grp_en = '0;
        set_grp(20, 4'h1, 4'h1, 3'd7); step();
        chk("R5 level7 pending", int'(level_out), 7);
        do_ack(3'd7, 0); exp_acc = 0;
        check_read("R5 sel zero");
        set_grp(20, 4'h0, 4'h0, 3'd0); step();
        chk("R5 empty", int'(level_out), 7);

        // random phase
        for (int it = 0; it < 400; it++) begin
            for (int g = FIRST; g < NG; g++) begin
                grp_req[g*SW +: SW] = 4'($urandom);
                grp_en[g*SW +: SW]  = ($urandom % 5 == 0) ? 4'($urandom) : 4'h0;
                grp_lvl[(g-FIRST)*LW +: LW] = 3'($urandom % 4);
            end
            step();
            check_level("R3 R4 random level");
            if (it % 3 == 0) begin
                model(s, l);
                do_ack(3'(l), 0); exp_acc = s;
                check_read("R7 R4 random capture");
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule